// File: doc/BRIEF.md
# Merged External Interrupt Pending and Enable Register

This block holds the software-visible pending and enable state for external interrupts at three privilege levels: user, supervisor and machine. For user and supervisor, the pending state has two sources: a flop that software may set or clear, and a live level-sensitive line from the platform interrupt controller. A read returns the OR of both sources. A set or clear access changes only the flop. Because the controller line never enters that read-modify-write, a higher privilege layer can inject an external interrupt for a lower one and later withdraw it without losing or latching a real controller request. The machine pending position is read-only and mirrors its controller line.

The surrounding CSR file presents one access per cycle. Each access carries an operation, a register select, a three-bit source operand aligned to the implemented positions, and the privilege of the issuing code. The block returns the read value in the same cycle. It applies the permitted part of the write on the next clock edge and flags any attempt to write a position the issuing mode does not own. Three request outputs combine the merged pending value with the enable bit of each level.

Top module: `irq_pend_csr`

## Requirements
- R1: A synchronous active-high reset clears every software pending bit and every enable bit. With all controller lines low, both registers then read zero.
- R2: Encodings. `csr_sel` 0 selects the pending register and 1 selects the enable register. In both registers bit 0 is user, bit 1 is supervisor and bit 2 is machine. `csr_op` values are 0 = none, 1 = swap, 2 = set, 3 = clear. `cur_priv` values are 0 = user, 1 = supervisor, 3 = machine.
- R3: The pending register reads bit 0 = user software bit OR `ext_usr`, bit 1 = supervisor software bit OR `ext_sup`, and bit 2 = `ext_mach`. `csr_rdata` follows the current state and inputs in the same cycle.
- R4: On the clock edge that ends an access, each permitted position is updated as follows. Swap loads the source bit. Set ORs the source bit into the stored bit. Clear removes the stored bit where the source bit is 1.
- R5: Set and clear compute the new pending value from the software bit alone. A controller line that is high during the access is never captured, so the position reads 0 once the line falls unless software set it.
- R6: The supervisor pending bit may be written only from machine mode. The user pending bit may be written from supervisor or machine mode. The machine enable bit may be written only from machine mode, the supervisor enable bit from supervisor or machine mode, and the user enable bit from any mode. Positions the mode does not own keep their value, while owned positions in the same access still update.
- R7: `csr_illegal` is high in the cycle of an access whose touched positions include one the mode does not own. Swap touches every writable position of the selected register. Set and clear touch the positions where the source bit is 1. Pending bit 2 is read-only: writes to it are ignored and never raise the flag.
- R8: A set or clear with an all-zero source operand changes nothing and does not raise `csr_illegal`.
- R9: `irq_usr` = (user software bit OR `ext_usr`) AND user enable. `irq_sup` = (supervisor software bit OR `ext_sup`) AND supervisor enable. `irq_mach` = `ext_mach` AND machine enable.
- R10: `pend_usr` and `pend_sup` carry the merged pending values, and `en_usr`, `en_sup` and `en_mach` carry the enable bits. All of these, and the enable register read, reflect a write from the clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | An access is presented this cycle |
| csr_op | input | 2 | Access operation: none, swap, set or clear |
| csr_sel | input | 1 | Register select: 0 = pending, 1 = enable |
| csr_wdata | input | 3 | Source operand or mask, aligned to the implemented positions |
| cur_priv | input | 2 | Privilege of the issuing code |
| ext_usr | input | 1 | User-level line from the interrupt controller |
| ext_sup | input | 1 | Supervisor-level line from the interrupt controller |
| ext_mach | input | 1 | Machine-level line from the interrupt controller |
| csr_rdata | output | 3 | Value of the selected register |
| csr_illegal | output | 1 | Access touches a position the mode does not own |
| pend_usr | output | 1 | Merged user pending value |
| pend_sup | output | 1 | Merged supervisor pending value |
| en_usr | output | 1 | User enable bit |
| en_sup | output | 1 | Supervisor enable bit |
| en_mach | output | 1 | Machine enable bit |
| irq_usr | output | 1 | User external interrupt request |
| irq_sup | output | 1 | Supervisor external interrupt request |
| irq_mach | output | 1 | Machine external interrupt request |

## Verification
The sharpest corner is a set or clear issued while a controller line is high. A design that feeds the merged value into the read-modify-write would latch the line, and the bench catches this by dropping the line afterwards and expecting the position to read 0. Mixed-permission accesses, such as supervisor mode setting both pending bits, expose a design that rejects the whole write, updates the protected bit, or fails to raise the flag. Zero-mask set and clear, and swaps that hit the read-only machine pending position, catch a design that flags or writes when it should not. A long run of mixed accesses and line toggles is then compared every cycle with a behavioural model.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SWAP = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } priv_e;

  // level positions inside both registers
  localparam int LVL_USR = 0;
  localparam int LVL_SUP = 1;
  localparam int LVL_MCH = 2;
  localparam int NUM_LVL = 3;

  // positions software may write, per register
  localparam logic [NUM_LVL-1:0] PEND_WR_MASK = 3'b011;
  localparam logic [NUM_LVL-1:0] ENA_WR_MASK  = 3'b111;

  // new stored value of one position for an access
  function automatic logic apply_op(csr_op_e op, logic old_v, logic src_v);
    case (op)
      OP_SWAP: return src_v;
      OP_SET:  return old_v | src_v;
      OP_CLR:  return old_v & ~src_v;
      default: return old_v;
    endcase
  endfunction

  // does the access touch this position at all
  function automatic logic touches(csr_op_e op, logic src_v, logic impl);
    case (op)
      OP_SWAP:        return impl;
      OP_SET, OP_CLR: return impl & src_v;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic may_write(priv_e cur, priv_e need);
    return cur >= need;
  endfunction

  function automatic priv_e pend_owner(int lvl);
    case (lvl)
      LVL_USR: return PRV_S;
      default: return PRV_M;
    endcase
  endfunction

  function automatic priv_e ena_owner(int lvl);
    case (lvl)
      LVL_USR: return PRV_U;
      LVL_SUP: return PRV_S;
      default: return PRV_M;
    endcase
  endfunction

endpackage

// File: rtl/irq_sw_bit.sv
module irq_sw_bit
  import irq_csr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  csr_op_e op,
  input  logic    src,
  output logic    q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (we) q <= apply_op(op, q, src);
  end

endmodule

// File: rtl/irq_wr_guard.sv
module irq_wr_guard
  import irq_csr_pkg::*;
(
  input  logic               acc_en,
  input  csr_op_e            op,
  input  logic               sel_ena,
  input  logic [NUM_LVL-1:0] src,
  input  priv_e              cur_priv,
  output logic [NUM_LVL-1:0] wr_pend,
  output logic [NUM_LVL-1:0] wr_ena,
  output logic               illegal
);

  logic [NUM_LVL-1:0] viol_pend;
  logic [NUM_LVL-1:0] viol_ena;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic hit_p, hit_e, ok_p, ok_e;
    assign hit_p = acc_en & ~sel_ena & touches(op, src[g], PEND_WR_MASK[g]);
    assign hit_e = acc_en &  sel_ena & touches(op, src[g], ENA_WR_MASK[g]);
    assign ok_p  = may_write(cur_priv, pend_owner(g));
    assign ok_e  = may_write(cur_priv, ena_owner(g));
    assign wr_pend[g]   = hit_p & ok_p;
    assign wr_ena[g]    = hit_e & ok_e;
    assign viol_pend[g] = hit_p & ~ok_p;
    assign viol_ena[g]  = hit_e & ~ok_e;
  end

  assign illegal = (|viol_pend) | (|viol_ena);

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
  import irq_csr_pkg::*;
(
  input  logic [NUM_LVL-1:0] pend,
  input  logic [NUM_LVL-1:0] ena,
  output logic [NUM_LVL-1:0] req
);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_req
    assign req[g] = pend[g] & ena[g];
  end

endmodule

// File: rtl/irq_pend_csr.sv
module irq_pend_csr
  import irq_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_en,
  input  logic [1:0]         csr_op,
  input  logic               csr_sel,
  input  logic [NUM_LVL-1:0] csr_wdata,
  input  logic [1:0]         cur_priv,
  input  logic               ext_usr,
  input  logic               ext_sup,
  input  logic               ext_mach,
  output logic [NUM_LVL-1:0] csr_rdata,
  output logic               csr_illegal,
  output logic               pend_usr,
  output logic               pend_sup,
  output logic               en_usr,
  output logic               en_sup,
  output logic               en_mach,
  output logic               irq_usr,
  output logic               irq_sup,
  output logic               irq_mach
);

  csr_op_e            op_e;
  priv_e              priv_v;
  logic [NUM_LVL-1:0] ext_vec;
  logic [NUM_LVL-1:0] sw_pend_q;
  logic [NUM_LVL-1:0] ena_q;
  logic [NUM_LVL-1:0] pend_merged;
  logic [NUM_LVL-1:0] wr_pend;
  logic [NUM_LVL-1:0] wr_ena;
  logic [NUM_LVL-1:0] req_vec;
  logic               illegal_w;

  assign op_e   = csr_op_e'(csr_op);
  assign priv_v = priv_e'(cur_priv);

  assign ext_vec[LVL_USR] = ext_usr;
  assign ext_vec[LVL_SUP] = ext_sup;
  assign ext_vec[LVL_MCH] = ext_mach;

  irq_wr_guard u_guard (
    .acc_en   (csr_en),
    .op       (op_e),
    .sel_ena  (csr_sel),
    .src      (csr_wdata),
    .cur_priv (priv_v),
    .wr_pend  (wr_pend),
    .wr_ena   (wr_ena),
    .illegal  (illegal_w)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bits
    irq_sw_bit u_pend (
      .clk (clk),
      .rst (rst),
      .we  (wr_pend[g]),
      .op  (op_e),
      .src (csr_wdata[g]),
      .q   (sw_pend_q[g])
    );
    irq_sw_bit u_ena (
      .clk (clk),
      .rst (rst),
      .we  (wr_ena[g]),
      .op  (op_e),
      .src (csr_wdata[g]),
      .q   (ena_q[g])
    );
    // merged view: software flop OR live controller line
    assign pend_merged[g] = sw_pend_q[g] | ext_vec[g];
  end

  irq_req_gate u_req (
    .pend (pend_merged),
    .ena  (ena_q),
    .req  (req_vec)
  );

  assign csr_rdata   = csr_sel ? ena_q : pend_merged;
  assign csr_illegal = illegal_w;
  assign pend_usr    = pend_merged[LVL_USR];
  assign pend_sup    = pend_merged[LVL_SUP];
  assign en_usr      = ena_q[LVL_USR];
  assign en_sup      = ena_q[LVL_SUP];
  assign en_mach     = ena_q[LVL_MCH];
  assign irq_usr     = req_vec[LVL_USR];
  assign irq_sup     = req_vec[LVL_SUP];
  assign irq_mach    = req_vec[LVL_MCH];

endmodule

// File: rtl/irq_pend_csr_chk.sv
module irq_pend_csr_chk (
  input logic       clk,
  input logic       rst,
  input logic       csr_en,
  input logic [1:0] csr_op,
  input logic       csr_sel,
  input logic [2:0] csr_wdata,
  input logic [1:0] cur_priv,
  input logic       ext_sup,
  input logic       ext_mach,
  input logic [2:0] sw_pend_q,
  input logic [2:0] ena_q,
  input logic [2:0] csr_rdata,
  input logic       csr_illegal,
  input logic       irq_mach
);

  // R5
  set_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_op == 2'd2 && !csr_sel && !csr_wdata[0])
      |=> (sw_pend_q[0] == $past(sw_pend_q[0])));

  // R6
  sup_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (!csr_sel && cur_priv != 2'd3) |=> $stable(sw_pend_q[1]));

  // R7
  usr_swap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_op == 2'd1 && !csr_sel && cur_priv == 2'd0) |-> csr_illegal);

  // R3
  merge_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!csr_sel) |-> (csr_rdata[1] == (sw_pend_q[1] | ext_sup)));

  // R9
  mach_req_chk: assert property (@(posedge clk) disable iff (rst)
    irq_mach |-> (ena_q[2] && ext_mach));

  // R4
  ena_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_op == 2'd1 && csr_sel && cur_priv == 2'd3)
      |=> (ena_q == $past(csr_wdata)));

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_op[1] && csr_wdata == 3'b000)
      |=> ($stable(ena_q) && $stable(sw_pend_q) && !$past(csr_illegal)));

endmodule

bind irq_pend_csr irq_pend_csr_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_en      (csr_en),
  .csr_op      (csr_op),
  .csr_sel     (csr_sel),
  .csr_wdata   (csr_wdata),
  .cur_priv    (cur_priv),
  .ext_sup     (ext_sup),
  .ext_mach    (ext_mach),
  .sw_pend_q   (sw_pend_q),
  .ena_q       (ena_q),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .irq_mach    (irq_mach)
);

// File: tb/tb_irq_pend_csr.sv
module tb_irq_pend_csr;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csr_en = 1'b0;
  logic [1:0] csr_op = 2'd0;
  logic       csr_sel = 1'b0;
  logic [2:0] csr_wdata = 3'b000;
  logic [1:0] cur_priv = 2'd3;
  logic       ext_usr = 1'b0, ext_sup = 1'b0, ext_mach = 1'b0;
  logic [2:0] csr_rdata;
  logic       csr_illegal, pend_usr, pend_sup, en_usr, en_sup, en_mach;
  logic       irq_usr, irq_sup, irq_mach;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_sw_u, m_sw_s;
  bit m_en_u, m_en_s, m_en_m;

  always #10 clk = ~clk;

  irq_pend_csr dut (
    .clk(clk), .rst(rst), .csr_en(csr_en), .csr_op(csr_op), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .cur_priv(cur_priv), .ext_usr(ext_usr),
    .ext_sup(ext_sup), .ext_mach(ext_mach), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .pend_usr(pend_usr), .pend_sup(pend_sup),
    .en_usr(en_usr), .en_sup(en_sup), .en_mach(en_mach),
    .irq_usr(irq_usr), .irq_sup(irq_sup), .irq_mach(irq_mach)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // minimum privilege code needed to write a position (R6)
  function automatic int owner(bit sel, int pos);
    if (!sel) return (pos == 0) ? 1 : 3;
    return (pos == 0) ? 0 : (pos == 1) ? 1 : 3;
  endfunction

  function automatic bit touched(int pos);
    bit writable;
    writable = csr_sel ? 1'b1 : (pos != 2);
    if (!csr_en || !writable) return 1'b0;
    if (csr_op == 2'd1) return 1'b1;
    if (csr_op >= 2'd2) return csr_wdata[pos];
    return 1'b0;
  endfunction

  function automatic bit m_illegal();
    bit r = 1'b0;
    for (int p = 0; p < 3; p++)
      if (touched(p) && int'(cur_priv) < owner(csr_sel, p)) r = 1'b1;
    return r;
  endfunction

  function automatic bit next_val(int pos, bit old);
    if (!touched(pos) || int'(cur_priv) < owner(csr_sel, pos)) return old;
    if (csr_op == 2'd1) return csr_wdata[pos];
    if (csr_op == 2'd2) return old | csr_wdata[pos];
    return csr_wdata[pos] ? 1'b0 : old;
  endfunction

  function automatic logic [2:0] m_pend();
    return {ext_mach, m_sw_s | ext_sup, m_sw_u | ext_usr};
  endfunction

  function automatic logic [2:0] m_ena();
    return {m_en_m, m_en_s, m_en_u};
  endfunction

  // drive one cycle's inputs and compare everything against the model
  task automatic drive(bit en, int op, bit sel, logic [2:0] wd, int pr,
                       bit eu, bit es, bit em);
    @(negedge clk);
    csr_en = en; csr_op = 2'(op); csr_sel = sel; csr_wdata = wd;
    cur_priv = 2'(pr); ext_usr = eu; ext_sup = es; ext_mach = em;
    #2;
    if (!rst) begin
      chk(sel ? "R10 enable read" : "R3 pending read", 8'(csr_rdata),
          8'(sel ? m_ena() : m_pend()));
      chk("R7 illegal flag", 8'(csr_illegal), 8'(m_illegal()));
      chk("R9 requests", 8'({irq_mach, irq_sup, irq_usr}),
          8'(m_pend() & m_ena()));
      chk("R10 level outputs", 8'({pend_sup, pend_usr, en_mach, en_sup, en_usr}),
          8'({m_sw_s | ext_sup, m_sw_u | ext_usr, m_en_m, m_en_s, m_en_u}));
    end
  endtask

  task automatic commit();
    bit nu, ns, neu, nes, nem;
    @(posedge clk);
    if (rst) begin
      nu = 0; ns = 0; neu = 0; nes = 0; nem = 0;
    end else if (!csr_sel) begin
      nu = next_val(0, m_sw_u); ns = next_val(1, m_sw_s);
      neu = m_en_u; nes = m_en_s; nem = m_en_m;
    end else begin
      nu = m_sw_u; ns = m_sw_s;
      neu = next_val(0, m_en_u); nes = next_val(1, m_en_s); nem = next_val(2, m_en_m);
    end
    m_sw_u = nu; m_sw_s = ns; m_en_u = neu; m_en_s = nes; m_en_m = nem;
  endtask

  task automatic cyc(bit en, int op, bit sel, logic [2:0] wd, int pr,
                     bit eu, bit es, bit em);
    drive(en, op, sel, wd, pr, eu, es, em);
    commit();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 3'b000, 3, 0, 0, 0);
    rst = 1'b0;

    // R1 reset state
    drive(0, 0, 0, 3'b000, 3, 0, 0, 0);
    chk("R1 pending after reset", 8'(csr_rdata), 8'h0);
    commit();
    drive(0, 0, 1, 3'b000, 3, 0, 0, 0);
    chk("R1 enable after reset", 8'(csr_rdata), 8'h0);
    commit();

    // R2 R4 machine swap of the enable register
    cyc(1, 1, 1, 3'b111, 3, 0, 0, 0);
    drive(0, 0, 1, 3'b000, 3, 0, 0, 0);
    chk("R4 enable swap", 8'(csr_rdata), 8'h7);
    commit();

    // R5 set user bit while supervisor line is high: line not captured
    cyc(1, 2, 0, 3'b001, 3, 0, 1, 0);
    drive(0, 0, 0, 3'b000, 3, 0, 0, 0);
    chk("R5 set does not latch line", 8'(csr_rdata), 8'h1);
    commit();

    // R5 clear user bit while user line is high
    cyc(1, 3, 0, 3'b001, 3, 1, 0, 0);
    drive(0, 0, 0, 3'b000, 3, 1, 0, 0);
    chk("R3 merged read with line high", 8'(csr_rdata), 8'h1);
    commit();
    drive(0, 0, 0, 3'b000, 3, 0, 0, 0);
    chk("R5 clear leaves bit cleared", 8'(csr_rdata), 8'h0);
    commit();

    // R6 R7 user mode may not set pending bits
    drive(1, 2, 0, 3'b011, 0, 0, 0, 0);
    chk("R7 user set flagged", 8'(csr_illegal), 8'h1);
    commit();
    drive(0, 0, 0, 3'b000, 3, 0, 0, 0);
    chk("R6 user write blocked", 8'(csr_rdata), 8'h0);
    commit();

    // R6 supervisor sets both: only the user bit lands
    drive(1, 2, 0, 3'b011, 1, 0, 0, 0);
    chk("R7 supervisor set flagged", 8'(csr_illegal), 8'h1);
    commit();
    drive(0, 0, 0, 3'b000, 3, 0, 0, 0);
    chk("R6 partial write", 8'(csr_rdata), 8'h1);
    commit();

    // R8 zero mask
    drive(1, 3, 0, 3'b000, 0, 0, 0, 0);
    chk("R8 zero mask no flag", 8'(csr_illegal), 8'h0);
    commit();
    drive(0, 0, 0, 3'b000, 3, 0, 0, 0);
    chk("R8 zero mask no change", 8'(csr_rdata), 8'h1);
    commit();

    // R7 machine swap hitting read-only bit 2
    drive(1, 1, 0, 3'b100, 3, 0, 0, 0);
    chk("R7 read-only bit not flagged", 8'(csr_illegal), 8'h0);
    commit();
    drive(0, 0, 0, 3'b000, 3, 0, 0, 0);
    chk("R7 read-only bit ignored", 8'(csr_rdata), 8'h0);
    commit();

    // R9 machine request
    drive(0, 0, 0, 3'b000, 3, 0, 0, 1);
    chk("R9 machine request", 8'(irq_mach), 8'h1);
    commit();

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int pr;
      pr = $urandom_range(0, 2);
      if (pr == 2) pr = 3;
      cyc(($urandom_range(0, 3) != 0), $urandom_range(0, 3), $urandom_range(0, 1),
          3'($urandom_range(0, 7)), pr, $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 1));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule